// File: doc/BRIEF.md
# DMA Channel with Double-Buffered Block Reload

This block is the register and sequencing core of one DMA channel. It keeps a 24-bit device address counter and a 24-bit remaining-length counter. An external bus engine moves the data and reports each finished transfer cycle on a strobe. On each strobe the block steps the two counters according to the mode bits.

Software can stage the next block's start address and length in shadow registers while the current block runs, and then set a valid flag. When the length counter reaches zero and the flag is set, the shadow values are loaded in the same cycle and the channel keeps running. When the flag is clear, the channel stops and records a sticky overrun.

A sticky terminal-count flag, two interrupt enables and a one-cycle interrupt pulse complete the status path. A channel-active output tells the bus engine when it may request the bus. The register bus has one write port and a separate combinational read port.

Top module: `dma_reload_chan`

## Requirements
- R1: After reset every register reads zero, `irq_o` is 0 and `chan_active_o` is 0.
- R2: A transfer is accepted when `xfer_done_i` is high while the channel is active. For each accepted transfer, the address counter (offset 3) does the following according to MODE (offset 0): it holds when MODE bit 0 (address update) is 0, adds 1 when bit 0 is 1 and bit 1 (decrement) is 0, and subtracts 1 when bits 0 and 1 are both 1.
- R3: Each accepted transfer lowers the length counter (offset 4) by one. A strobe while the channel is inactive changes neither counter.
- R4: `chan_active_o` and STAT (offset 1) bit 3 equal CNTL (offset 2) bit 0 (enable) AND a nonzero length counter. Writes to STAT bit 3 are ignored.
- R5: A block completes when an accepted transfer takes the length counter to zero. If CNTL bit 1 (next valid) is set at that point, the address and length counters load the shadow address (offset 5) and shadow length (offset 6) on that edge, next valid clears, enable stays 1, and STAT bit 0 (terminal count) sets.
- R6: If a block completes with next valid clear, STAT bit 0 and STAT bit 2 (overrun) set, enable clears, and the length counter stays at zero.
- R7: STAT bits 0 and 2 are sticky. Writing 1 to one of these bits clears it, and writing 0 leaves it unchanged. A set event in the same cycle as a clear takes priority. STAT bits 4 and 6 are plain read/write interrupt enables.
- R8: `irq_o` is high for the single cycle after a completing edge. It is raised when STAT bit 4 is set, or when that completion sets the overrun and STAT bit 6 is set. It is low otherwise.
- R9: Counter and shadow registers keep bits 23:0 of a write, and bits 31:24 read as zero. Bits of MODE, STAT and CNTL that are not defined read as zero.
- R10: If the loaded shadow length is zero while enable is 1, the block completes again on the next clock edge. This second completion also follows R5/R6, so with next valid clear it sets the overrun and stops the channel.
- R11: `dir_o` follows MODE bit 2: 0 means the I/O device is the destination, 1 means it is the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write offset |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read offset |
| rd_data_o | output | 32 | Read data, combinational from `rd_addr_i` |
| xfer_done_i | input | 1 | One transfer cycle finished by the bus engine |
| irq_o | output | 1 | Interrupt pulse |
| chan_active_o | output | 1 | Channel enabled with a nonzero remaining length |
| dir_o | output | 1 | Transfer direction relative to the I/O device |

## Verification
Register reads are combinational, so a value can be checked in the cycle in which it is addressed. Counter, status and control updates from a write or strobe sampled on a rising edge appear right after that edge, and `irq_o` is high only in that following cycle. A zero-length reload produces a second completion one edge later. The driver applies each stimulus for exactly one rising edge and queues the expected results at that moment. The monitor compares them at the next falling edge, and it checks the follow-up results after further single-cycle waits so that each one is sampled in the cycle it is due.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_MODE  = 3'd0;
  localparam logic [REG_AW-1:0] RA_STAT  = 3'd1;
  localparam logic [REG_AW-1:0] RA_CNTL  = 3'd2;
  localparam logic [REG_AW-1:0] RA_ADDR  = 3'd3;
  localparam logic [REG_AW-1:0] RA_LEN   = 3'd4;
  localparam logic [REG_AW-1:0] RA_NADDR = 3'd5;
  localparam logic [REG_AW-1:0] RA_NLEN  = 3'd6;

  localparam int ST_TC    = 0;
  localparam int ST_OVR   = 2;
  localparam int ST_ACT   = 3;
  localparam int ST_TCIE  = 4;
  localparam int ST_OVRIE = 6;

  localparam int CT_EN  = 0;
  localparam int CT_VLD = 1;

  localparam int MODE_W = 3;

  typedef struct packed {
    logic dir;
    logic dec;
    logic upd;
  } mode_t;
endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sw_we_i,
  input  logic [W-1:0] sw_d_i,
  input  logic         step_i,
  input  logic         upd_i,
  input  logic         dec_i,
  input  logic         load_i,
  input  logic [W-1:0] load_d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q <= '0;
    else if (load_i)            q <= load_d_i;
    else if (step_i && upd_i)   q <= dec_i ? q - W'(1) : q + W'(1);
    else if (sw_we_i)           q <= sw_d_i;
  end

  assign q_o = q;

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !upd_i && !load_i && !sw_we_i) |=> (q_o == $past(q_o)));
  assert_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && upd_i && !dec_i && !load_i) |=> (q_o == $past(q_o) + W'(1)));
  assert_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && upd_i && dec_i && !load_i) |=> (q_o == $past(q_o) - W'(1)));
endmodule

// File: rtl/dma_len_ctr.sv
module dma_len_ctr #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sw_we_i,
  input  logic [W-1:0] sw_d_i,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [W-1:0] load_d_i,
  output logic [W-1:0] q_o,
  output logic         zero_o,
  output logic         last_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q <= '0;
    else if (load_i)    q <= load_d_i;
    else if (step_i)    q <= q - W'(1);
    else if (sw_we_i)   q <= sw_d_i;
  end

  assign q_o    = q;
  assign zero_o = (q == '0);
  assign last_o = (q == W'(1));

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (q_o == $past(q_o) - W'(1)));
  assert_step_live_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !zero_o);
endmodule

// File: rtl/dma_status.sv
module dma_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic ovr_evt_i,
  input  logic sw_we_i,
  input  logic tc_clr_i,
  input  logic ovr_clr_i,
  input  logic tcie_d_i,
  input  logic ovrie_d_i,
  output logic tc_o,
  output logic ovr_o,
  output logic tcie_o,
  output logic ovrie_o,
  output logic irq_o
);
  logic tc_q, ovr_q, tcie_q, ovrie_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q    <= 1'b0;
      ovr_q   <= 1'b0;
      tcie_q  <= 1'b0;
      ovrie_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      // set events win over a same-cycle clear
      if (done_i)                      tc_q <= 1'b1;
      else if (sw_we_i && tc_clr_i)    tc_q <= 1'b0;
      if (ovr_evt_i)                   ovr_q <= 1'b1;
      else if (sw_we_i && ovr_clr_i)   ovr_q <= 1'b0;
      if (sw_we_i) begin
        tcie_q  <= tcie_d_i;
        ovrie_q <= ovrie_d_i;
      end
      irq_q <= done_i & (tcie_q | (ovr_evt_i & ovrie_q));
    end
  end

  assign tc_o    = tc_q;
  assign ovr_o   = ovr_q;
  assign tcie_o  = tcie_q;
  assign ovrie_o = ovrie_q;
  assign irq_o   = irq_q;

  assert_tc_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !(sw_we_i && tc_clr_i)) |=> tc_o);
  assert_ovr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !(sw_we_i && ovr_clr_i)) |=> ovr_o);
  assert_tc_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && tc_clr_i && !done_i) |=> !tc_o);
  assert_irq_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(done_i));
endmodule

// File: rtl/dma_reload_chan.sv
module dma_reload_chan
  import dma_ch_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              xfer_done_i,
  output logic              irq_o,
  output logic              chan_active_o,
  output logic              dir_o
);
  localparam int CNT_W = (ADDR_W > LEN_W) ? ADDR_W : LEN_W;

  mode_t             mode_q;
  logic              en_q, vld_q;
  logic [ADDR_W-1:0] naddr_q, addr_q;
  logic [LEN_W-1:0]  nlen_q, len_q;
  logic              len_zero, len_last;
  logic              tc, ovr, tcie, ovrie;

  logic we_mode, we_stat, we_cntl, we_addr, we_len, we_naddr, we_nlen;
  assign we_mode  = wr_en_i && (wr_addr_i == RA_MODE);
  assign we_stat  = wr_en_i && (wr_addr_i == RA_STAT);
  assign we_cntl  = wr_en_i && (wr_addr_i == RA_CNTL);
  assign we_addr  = wr_en_i && (wr_addr_i == RA_ADDR);
  assign we_len   = wr_en_i && (wr_addr_i == RA_LEN);
  assign we_naddr = wr_en_i && (wr_addr_i == RA_NADDR);
  assign we_nlen  = wr_en_i && (wr_addr_i == RA_NLEN);

  logic active, step, complete, reload, ovr_evt;
  assign active   = en_q & ~len_zero;
  assign step     = xfer_done_i & active;
  // a zero length with enable set counts as an immediate completion
  assign complete = en_q & (len_zero | (step & len_last));
  assign reload   = complete & vld_q;
  assign ovr_evt  = complete & ~vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      en_q    <= 1'b0;
      vld_q   <= 1'b0;
      naddr_q <= '0;
      nlen_q  <= '0;
    end else begin
      if (we_mode)       mode_q <= mode_t'(wr_data_i[MODE_W-1:0]);
      if (ovr_evt)       en_q <= 1'b0;
      else if (we_cntl)  en_q <= wr_data_i[CT_EN];
      if (reload)        vld_q <= 1'b0;
      else if (we_cntl)  vld_q <= wr_data_i[CT_VLD];
      if (we_naddr)      naddr_q <= wr_data_i[ADDR_W-1:0];
      if (we_nlen)       nlen_q  <= wr_data_i[LEN_W-1:0];
    end
  end

  dma_addr_ctr #(.W(ADDR_W)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_we_i  (we_addr),
    .sw_d_i   (wr_data_i[ADDR_W-1:0]),
    .step_i   (step),
    .upd_i    (mode_q.upd),
    .dec_i    (mode_q.dec),
    .load_i   (reload),
    .load_d_i (naddr_q),
    .q_o      (addr_q)
  );

  dma_len_ctr #(.W(LEN_W)) u_len (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_we_i  (we_len),
    .sw_d_i   (wr_data_i[LEN_W-1:0]),
    .step_i   (step),
    .load_i   (reload),
    .load_d_i (nlen_q),
    .q_o      (len_q),
    .zero_o   (len_zero),
    .last_o   (len_last)
  );

  dma_status u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (complete),
    .ovr_evt_i (ovr_evt),
    .sw_we_i   (we_stat),
    .tc_clr_i  (wr_data_i[ST_TC]),
    .ovr_clr_i (wr_data_i[ST_OVR]),
    .tcie_d_i  (wr_data_i[ST_TCIE]),
    .ovrie_d_i (wr_data_i[ST_OVRIE]),
    .tc_o      (tc),
    .ovr_o     (ovr),
    .tcie_o    (tcie),
    .ovrie_o   (ovrie),
    .irq_o     (irq_o)
  );

  logic unused_wdata;
  assign unused_wdata = ^wr_data_i[DATA_W-1:CNT_W];

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      RA_MODE:  rd_data_o[MODE_W-1:0] = mode_q;
      RA_STAT: begin
        rd_data_o[ST_TC]    = tc;
        rd_data_o[ST_OVR]   = ovr;
        rd_data_o[ST_ACT]   = active;
        rd_data_o[ST_TCIE]  = tcie;
        rd_data_o[ST_OVRIE] = ovrie;
      end
      RA_CNTL: begin
        rd_data_o[CT_EN]  = en_q;
        rd_data_o[CT_VLD] = vld_q;
      end
      RA_ADDR:  rd_data_o[ADDR_W-1:0] = addr_q;
      RA_LEN:   rd_data_o[LEN_W-1:0]  = len_q;
      RA_NADDR: rd_data_o[ADDR_W-1:0] = naddr_q;
      RA_NLEN:  rd_data_o[LEN_W-1:0]  = nlen_q;
      default:  ;
    endcase
  end

  assign chan_active_o = active;
  assign dir_o         = mode_q.dir;

  assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload && !we_cntl) |=> (len_q == $past(nlen_q)) && (addr_q == $past(naddr_q))
                             && !vld_q && en_q && tc);
  assert_ovr_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_evt |=> (!en_q && ovr && tc && len_zero));
  assert_zero_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && len_zero && !vld_q) |=> !en_q);
  assert_active_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !chan_active_o);
endmodule

// File: tb/dma_reload_chan_bench.sv
`timescale 1ns/1ps
module dma_reload_chan_bench;
  localparam time TCLK = 20ns;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        xfer = 1'b0;
  logic        irq, active, dir;

  int n_run = 0;
  int n_fail = 0;

  always #(TCLK/2) clk = ~clk;

  dma_reload_chan u_dma_reload_chan (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en),
    .wr_addr_i     (wr_addr),
    .wr_data_i     (wr_data),
    .rd_addr_i     (rd_addr),
    .rd_data_o     (rd_data),
    .xfer_done_i   (xfer),
    .irq_o         (irq),
    .chan_active_o (active),
    .dir_o         (dir)
  );

  // kind: 0 register read, 1 irq, 2 channel active, 3 direction
  typedef struct {
    int          kind;
    logic [2:0]  a;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];

  task automatic expect_item(input int kind, input logic [2:0] a,
                             input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.a = a; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [31:0] v, input string tag);
    expect_item(0, a, v, tag);
  endtask

  task automatic exp_pin(input int kind, input logic v, input string tag);
    expect_item(kind, 3'd0, {31'd0, v}, tag);
  endtask

  // monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = sb.pop_front();
        rd_addr = it.a;
        #1;
        case (it.kind)
          0: got = rd_data;
          1: got = {31'd0, irq};
          2: got = {31'd0, active};
          default: got = {31'd0, dir};
        endcase
        n_run++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic pulse_xfer();
    @(posedge clk); #2;
    xfer = 1'b1;
    @(posedge clk); #2;
    xfer = 1'b0;
  endtask

  task automatic cycle();
    @(posedge clk); #2;
  endtask

  bit finished = 1'b0;

  initial begin
    #(200000 * TCLK);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    // R1 reset state
    exp_rd(3'd0, 32'h0, "R1 mode");
    exp_rd(3'd1, 32'h0, "R1 stat");
    exp_rd(3'd2, 32'h0, "R1 cntl");
    exp_rd(3'd3, 32'h0, "R1 addr");
    exp_rd(3'd4, 32'h0, "R1 len");
    exp_pin(1, 1'b0, "R1 irq");
    exp_pin(2, 1'b0, "R1 active");
    cycle();

    // R9 upper bits dropped
    wr(3'd3, 32'hFF12_3456);
    exp_rd(3'd3, 32'h0012_3456, "R9 addr upper bits");
    wr(3'd4, 32'hAB00_0004);
    exp_rd(3'd4, 32'h0000_0004, "R9 len upper bits");
    exp_pin(2, 1'b0, "R4 inactive while disabled");
    // R3 strobe ignored while inactive
    pulse_xfer();
    exp_rd(3'd4, 32'h4, "R3 strobe ignored len");
    exp_rd(3'd3, 32'h0012_3456, "R3 strobe ignored addr");

    wr(3'd0, 32'h1);
    wr(3'd1, 32'h58);          // bit 3 write must be ignored
    exp_rd(3'd1, 32'h50, "R4 stat act write ignored");
    wr(3'd2, 32'h1);
    exp_pin(2, 1'b1, "R4 active when enabled");
    exp_rd(3'd1, 32'h58, "R4 stat act bit");

    // R2 increment
    pulse_xfer();
    exp_rd(3'd3, 32'h0012_3457, "R2 increment");
    exp_rd(3'd4, 32'h3, "R3 decrement len");
    exp_pin(1, 1'b0, "R8 no irq mid block");
    // R2 decrement
    wr(3'd0, 32'h3);
    pulse_xfer();
    exp_rd(3'd3, 32'h0012_3456, "R2 decrement");
    exp_rd(3'd4, 32'h2, "R3 len 2");
    // R2 hold
    wr(3'd0, 32'h0);
    pulse_xfer();
    exp_rd(3'd3, 32'h0012_3456, "R2 hold");
    exp_rd(3'd4, 32'h1, "R3 len 1");

    // R5 reload with valid
    wr(3'd5, 32'h77AB_CDEF);
    wr(3'd6, 32'h0000_0002);
    exp_rd(3'd5, 32'h00AB_CDEF, "R9 shadow addr");
    wr(3'd2, 32'h3);
    exp_rd(3'd2, 32'h3, "R5 valid set");
    pulse_xfer();
    exp_rd(3'd3, 32'h00AB_CDEF, "R5 addr reload");
    exp_rd(3'd4, 32'h2, "R5 len reload");
    exp_rd(3'd2, 32'h1, "R5 valid cleared enable kept");
    exp_rd(3'd1, 32'h59, "R5 tc set");
    exp_pin(1, 1'b1, "R8 irq on tc");
    exp_pin(2, 1'b1, "R5 still active");
    cycle();
    exp_pin(1, 1'b0, "R8 irq one cycle");

    // R7 write-0 no effect, write-1 clears
    wr(3'd1, 32'h50);
    exp_rd(3'd1, 32'h59, "R7 write 0 keeps tc");
    wr(3'd1, 32'h51);
    exp_rd(3'd1, 32'h58, "R7 write 1 clears tc");

    // R6 completion without valid
    wr(3'd1, 32'h40);
    exp_rd(3'd1, 32'h48, "R7 enables written");
    pulse_xfer();
    exp_rd(3'd4, 32'h1, "R3 len 1 again");
    pulse_xfer();
    exp_rd(3'd1, 32'h45, "R6 overrun and tc");
    exp_rd(3'd2, 32'h0, "R6 enable cleared");
    exp_rd(3'd4, 32'h0, "R6 len zero");
    exp_pin(1, 1'b1, "R8 irq on overrun");
    exp_pin(2, 1'b0, "R4 inactive after stop");
    cycle();
    exp_pin(1, 1'b0, "R8 irq dropped");
    pulse_xfer();
    exp_rd(3'd3, 32'h00AB_CDEF, "R3 stopped addr unchanged");
    exp_pin(1, 1'b0, "R8 no irq when stopped");

    wr(3'd1, 32'h44);
    exp_rd(3'd1, 32'h41, "R7 overrun cleared tc kept");
    wr(3'd1, 32'h01);
    exp_rd(3'd1, 32'h00, "R7 all cleared");

    // R10 zero-length reload
    wr(3'd6, 32'h0);
    wr(3'd5, 32'h100);
    wr(3'd4, 32'h1);
    wr(3'd1, 32'h10);
    wr(3'd0, 32'h1);
    wr(3'd2, 32'h3);
    pulse_xfer();
    exp_rd(3'd3, 32'h100, "R10 addr reload");
    exp_rd(3'd4, 32'h0, "R10 len zero loaded");
    exp_rd(3'd2, 32'h1, "R10 enable kept");
    exp_rd(3'd1, 32'h11, "R10 tc set");
    exp_pin(1, 1'b1, "R10 first irq");
    cycle();
    exp_rd(3'd2, 32'h0, "R10 stopped next cycle");
    exp_rd(3'd1, 32'h15, "R10 overrun next cycle");
    exp_rd(3'd3, 32'h100, "R10 addr held");
    exp_pin(1, 1'b1, "R10 second irq");
    cycle();
    exp_pin(1, 1'b0, "R10 irq ends");

    // R11 direction
    exp_pin(3, 1'b0, "R11 dir 0");
    wr(3'd0, 32'hFFFF_FFFC);
    exp_pin(3, 1'b1, "R11 dir 1");
    exp_rd(3'd0, 32'h4, "R9 mode reserved bits zero");
    exp_rd(3'd7, 32'h0, "R9 unused offset");
    cycle();
    cycle();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule